// File: doc/BRIEF.md
# Seeded Bit-Inversion RAM Self-Test Engine

This block exercises a synchronous single-port RAM with a short, non-linear address walk rather than a sweep of the whole array. The walk is built from a handful of background "seed" addresses. For each seed the engine visits the seed itself, and then the seed with one address bit flipped, taking the bits from least to most significant. Every address in such a group is written with a fresh pseudo-random word from an internal LFSR. The group is then read back in the opposite order and each returned word is compared with the word stored there.

A caller picks a coverage level with a two-bit selector and pulses `start`. More seeds find more faults and take longer: 2, 4 or 8 seeds cost 4N+4, 8N+8 or 16N+16 RAM accesses. On the first mismatch the engine stops and holds the failing address, the expected word and the returned word. Otherwise it reports a clean pass.

Top module: `seeded_ram_bist`

## Requirements
- R1: After reset `done` and `fail` are low, and neither `ram_we` nor `ram_re` is asserted.
- R2: The seed count is taken from `seed_sel` in the cycle where `start` is accepted: 2'b00 selects 2 seeds, 2'b01 selects 4, and 2'b10 or 2'b11 selects 8. Seeds are visited in this order. For N=8 they are 0x00, 0xFF, 0x0F, 0xF0, 0x33, 0xCC, 0x55, 0xAA. In general: all zeros, all ones, low half set, high half set, bit pairs (bit i set when i mod 4 < 2), its inverse, even bits set, odd bits set.
- R3: For each seed, N+1 writes are issued on consecutive cycles, one access per cycle. The addresses are the seed, then the seed with bit 0 inverted, bit 1 inverted, and so on up to bit N-1. The first write is issued in the cycle after `start` is accepted.
- R4: Right after a seed's last write, its N+1 addresses are read on consecutive cycles in exactly the reverse order. The next seed's first write follows the last read with no gap.
- R5: `ram_wdata` comes from a W-bit Galois LFSR (right shift, tap mask 0xB8 for W=8, state 1 at each start) that advances on each write. The words written within one seed's group are all different.
- R6: Read data is taken one cycle after `ram_re`. The first word that differs from the value written in the current seed's group sets `fail` and captures `fail_addr`, `fail_exp` and `fail_act`.
- R7: No access is issued in the cycle the mismatch is seen or afterwards. `done` rises on the next cycle.
- R8: With no mismatch, the run issues exactly 2(N+1)·S accesses, where S is the seed count. The cycle after the last read has no access, and `done` rises one cycle later with `fail` low.
- R9: `start` is ignored while a run is active. `done` and the captured results hold until a new `start`. A new `start` clears `fail` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| seed_sel | input | 2 | Seed count select |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after `ram_re` |
| done | output | 1 | Run finished |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Word that was written there |
| fail_act | output | DW | Word that was read back |

## Verification
The tight spot is the seed boundary. The compare of a seed's final read, which is always at the seed address itself, lands in the same cycle as the first write of the next seed. The bench provokes this by corrupting reads of address 0x00, which is only the final read of the first seed. The reference model then expects the next seed's write to be withheld in that cycle, `done` to rise one cycle later, and the captured address and words to match the corrupted read. Faults deeper inside later seeds, and a spurious `start` part-way through a run, are judged the same way against a per-cycle expected access list.

// File: rtl/seeded_ram_bist.sv
`timescale 1ns/1ps
module seeded_ram_bist #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [DW-1:0] TAPS = 'hB8,
  parameter logic [DW-1:0] LFSR_INIT = 'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    seed_sel,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act
);
  localparam int PW = $clog2(AW + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_DRAIN, S_DONE} state_t;

  state_t        state;
  logic [2:0]    seed_idx, last_seed;
  logic [PW-1:0] pos;
  logic [DW-1:0] lfsr;
  logic [DW-1:0] wbuf [0:AW];
  logic          rd_v;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] rd_exp_q;
  logic [AW-1:0] flip, cur_addr;
  logic          mism, act;

  function automatic logic [AW-1:0] seed_of(input logic [2:0] k);
    logic [AW-1:0] b;
    for (int i = 0; i < AW; i++) begin
      case (k[2:1])
        2'd0:    b[i] = 1'b0;
        2'd1:    b[i] = (i < AW / 2);
        2'd2:    b[i] = ((i % 4) < 2);
        default: b[i] = ((i % 2) == 0);
      endcase
    end
    return k[0] ? ~b : b;
  endfunction

  always_comb
    for (int i = 0; i < AW; i++) flip[i] = (pos == PW'(i + 1));

  assign cur_addr  = seed_of(seed_idx) ^ flip;
  assign mism      = rd_v && (ram_rdata != rd_exp_q);
  assign act       = (state == S_WR || state == S_RD) && !mism;
  assign ram_we    = act && state == S_WR;
  assign ram_re    = act && state == S_RD;
  assign ram_addr  = cur_addr;
  assign ram_wdata = lfsr;
  assign done      = (state == S_DONE);

  always_ff @(posedge clk)
    if (state == S_WR) wbuf[pos] <= lfsr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      seed_idx  <= '0;
      last_seed <= '0;
      pos       <= '0;
      lfsr      <= LFSR_INIT;
      rd_v      <= 1'b0;
      rd_addr_q <= '0;
      rd_exp_q  <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else begin
      rd_v      <= ram_re;
      rd_addr_q <= cur_addr;
      rd_exp_q  <= wbuf[pos];
      if (mism) begin
        fail      <= 1'b1;
        fail_addr <= rd_addr_q;
        fail_exp  <= rd_exp_q;
        fail_act  <= ram_rdata;
        state     <= S_DONE;
      end else begin
        case (state)
          S_IDLE, S_DONE:
            if (start) begin
              case (seed_sel)
                2'b00:   last_seed <= 3'd1;
                2'b01:   last_seed <= 3'd3;
                default: last_seed <= 3'd7;
              endcase
              seed_idx  <= '0;
              pos       <= '0;
              lfsr      <= LFSR_INIT;
              fail      <= 1'b0;
              fail_addr <= '0;
              fail_exp  <= '0;
              fail_act  <= '0;
              state     <= S_WR;
            end
          S_WR: begin
            lfsr <= {1'b0, lfsr[DW-1:1]} ^ (lfsr[0] ? TAPS : '0);
            if (pos == PW'(AW)) state <= S_RD;
            else pos <= pos + 1'b1;
          end
          S_RD:
            if (pos == '0) begin
              if (seed_idx == last_seed) state <= S_DRAIN;
              else begin
                seed_idx <= seed_idx + 1'b1;
                state    <= S_WR;
              end
            end else pos <= pos - 1'b1;
          S_DRAIN: state <= S_DONE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_quiet_after_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!ram_we && !ram_re));

  assert_single_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> ($countones(ram_addr ^ seed_of(seed_idx)) <= 1));

  assert_read_starts_at_last_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && !$past(ram_re)) |-> ($past(ram_we) && ram_addr == $past(ram_addr)));

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(fail) && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_act)));
endmodule

// File: tb/seeded_ram_bist_tb.sv
`timescale 1ns/1ps
module seeded_ram_bist_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] seed_sel = 2'b00;
  logic       ram_we, ram_re, done, fail;
  logic [7:0] ram_addr, ram_wdata, ram_rdata, fail_addr, fail_exp, fail_act;

  logic       flt_on = 1'b0;
  logic [7:0] flt_addr = 8'h00, flt_mask = 8'h00;
  logic [7:0] mem [256];

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  seeded_ram_bist #(.AW(8), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_sel(seed_sel),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act));

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr] ^ ((flt_on && ram_addr == flt_addr) ? flt_mask : 8'h00);
  end

  task automatic chk(input bit ok, input string req, input string what, input int actv, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
    end
  endtask

  function automatic logic [7:0] bench_seed(input int k);
    case (k)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'h0F; 3: return 8'hF0;
      4: return 8'h33; 5: return 8'hCC; 6: return 8'h55; default: return 8'hAA;
    endcase
  endfunction

  task automatic run(input logic [1:0] sel, input bit fon, input logic [7:0] faddr,
                     input logic [7:0] fmask, input bit stray_start);
    logic [8:0] q[$];
    logic [7:0] shadow [256];
    logic [7:0] words[$];
    int nseeds, accesses, step;
    bit expect_fail, prev_rd;
    logic [7:0] e_addr, e_exp, e_act;
    nseeds = (sel == 2'b00) ? 2 : (sel == 2'b01) ? 4 : 8;
    for (int s = 0; s < nseeds; s++) begin
      for (int i = 0; i <= 8; i++)
        q.push_back({1'b0, (i == 0) ? bench_seed(s) : bench_seed(s) ^ (8'h01 << (i - 1))});
      for (int i = 8; i >= 0; i--)
        q.push_back({1'b1, (i == 0) ? bench_seed(s) : bench_seed(s) ^ (8'h01 << (i - 1))});
    end
    flt_on = fon; flt_addr = faddr; flt_mask = fmask;
    @(negedge clk);
    start = 1'b1; seed_sel = sel;
    expect_fail = 1'b0; accesses = 0; prev_rd = 1'b0; step = 0;
    e_addr = 0; e_exp = 0; e_act = 0;
    while (q.size() > 0) begin
      logic [8:0] e;
      @(negedge clk);
      start = 1'b0; seed_sel = ~sel;
      if (stray_start && step == 5) begin start = 1'b1; seed_sel = 2'b11; end
      step++;
      e = q.pop_front();
      if (ram_we || ram_re) accesses++;
      chk(ram_we == !e[8] && ram_re == e[8], "R3", "access kind", {ram_we, ram_re}, {!e[8], e[8]});
      chk(ram_addr == e[7:0], e[8] ? "R4" : "R2", "address", ram_addr, e[7:0]);
      if (!e[8]) begin
        if (prev_rd) words.delete();
        chk(!(ram_wdata inside {words}), "R5", "repeated word in group", ram_wdata, 0);
        words.push_back(ram_wdata);
        shadow[e[7:0]] = ram_wdata;
      end
      prev_rd = e[8];
      if (e[8] && fon && fmask != 0 && e[7:0] == faddr) begin
        expect_fail = 1'b1;
        e_addr = faddr; e_exp = shadow[faddr]; e_act = shadow[faddr] ^ fmask;
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(!ram_we && !ram_re, expect_fail ? "R7" : "R8", "idle after last read", {ram_we, ram_re}, 0);
    chk(!done, expect_fail ? "R7" : "R8", "done early", done, 0);
    @(negedge clk);
    chk(done, expect_fail ? "R7" : "R8", "done", done, 1);
    chk(fail == expect_fail, "R6", "fail flag", fail, expect_fail);
    if (expect_fail) begin
      chk(fail_addr == e_addr, "R6", "fail_addr", fail_addr, e_addr);
      chk(fail_exp == e_exp, "R6", "fail_exp", fail_exp, e_exp);
      chk(fail_act == e_act, "R6", "fail_act", fail_act, e_act);
    end else
      chk(accesses == 2 * 9 * nseeds, "R8", "access count", accesses, 2 * 9 * nseeds);
    repeat (3) @(negedge clk);
    chk(done && fail == expect_fail && fail_addr == e_addr, "R9", "results held", fail_addr, e_addr);
    flt_on = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!done && !fail && !ram_we && !ram_re, "R1", "reset state", {done, fail, ram_we, ram_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !fail && !ram_we && !ram_re, "R1", "idle after reset", {done, fail, ram_we, ram_re}, 0);
    run(2'b00, 1'b0, 8'h00, 8'h00, 1'b0);
    run(2'b01, 1'b0, 8'h00, 8'h00, 1'b1);
    run(2'b10, 1'b0, 8'h00, 8'h00, 1'b0);
    run(2'b11, 1'b0, 8'h00, 8'h00, 1'b1);
    run(2'b00, 1'b1, 8'h00, 8'h01, 1'b0);
    run(2'b01, 1'b1, 8'h1F, 8'h80, 1'b0);
    run(2'b11, 1'b1, 8'h2A, 8'h10, 1'b1);
    run(2'b00, 1'b1, 8'h55, 8'h04, 1'b0);
    run(2'b10, 1'b1, 8'hAB, 8'hFF, 1'b0);
    run(2'b01, 1'b0, 8'h00, 8'h00, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule